// File: doc/BRIEF.md
# Auxiliary Voltage Detector Interrupt Logic

This block is the digital back end of an auxiliary supply monitor. Two analog comparators, one watching the main supply and one watching an external voltage pin, deliver outputs that already carry their hysteresis. The block brings both into the clock domain and selects one of them through a configuration bit. It shows the selected level as a live, read-only flag and latches an interrupt request whenever that level changes in either direction, if interrupts are enabled.

The whole function depends on a static low-voltage reset option input. While that option is off, the flag reads 0 and no request is produced. Level changes that complete while the chip is still counting its power-up reset delay are not reported. Software reaches the block through one small control/status register, with separate write and read strobes. The request stays pending until software acknowledges it with a write. Changing the source never raises a request by itself.

Top module: `vdet_irq`

## Requirements
- R1: Write bit 1 (select) chooses the source: 0 means the main-supply comparator and 1 means the external-pin comparator. The selected value reads back at read bit 1.
- R2: Read bit 3 is the flag. It equals the selected comparator input after a SYNC_STAGES-flop synchronizer, so an input change shows up SYNC_STAGES clocks later. The flag has no write field.
- R3: With the enable (write/read bit 0) set, both a rising and a falling transition of the flag set the pending request. The request appears on irqReq one clock after the flag changes.
- R4: While lvrOptEn is low, the flag reads 0 and irqReq never rises. A transition seen in the first cycle after the option turns on is ignored.
- R5: A write that sets the enable while it was 0 and the flag is 1 sets pending on that clock. A later flag transition sets it again once it has been acknowledged.
- R6: While rstDelayBusy is high, no flag transition and no enabling write sets pending. A transition absorbed during the delay is not reported once the delay ends.
- R7: After reset, enable, select, pending, irqReq and regRdata are all 0.
- R8: Pending (read bit 2, also driven on irqReq) holds until a write with bit 2 set clears it. If a set and a clear fall on the same clock, the set wins.
- R9: A write that changes the select sets no pending by itself, even when the two comparators disagree.
- R10: A read strobe captures {flag, pending, select, enable} in bits 3..0 of regRdata on that clock. regRdata keeps its value between strobes.
- R11: With the enable at 0, flag transitions leave pending unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyCmp | input | 1 | Main-supply comparator output (asynchronous) |
| extCmp | input | 1 | External-pin comparator output (asynchronous) |
| lvrOptEn | input | 1 | Low-voltage reset option enabled |
| rstDelayBusy | input | 1 | High during the power-up reset delay |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 3 | Write data: bit 0 enable, bit 1 select, bit 2 acknowledge |
| regRd | input | 1 | Register read strobe |
| regRdata | output | 4 | Captured read data: bit 0 enable, bit 1 select, bit 2 pending, bit 3 flag |
| irqReq | output | 1 | Interrupt request (pending bit) |

## Verification
The bench builds the block with SYNC_STAGES at 3 rather than the default 2. This makes the model's delay line longer than the default and checks that every flag and request timing follows the parameter. With that depth, a select change can land while an older input edge is still inside the synchronizer. That interleaving is what shows whether the edge-detector reload suppresses only the source switch and not a genuine crossing. A long random phase also toggles the option and the reset-delay input. This places enable writes, acknowledges and transitions on the same clock, so the set-over-clear priority is exercised.

// File: rtl/vdet_pkg.sv
package vdet_pkg;
  localparam int WR_W = 3;
  localparam int RD_W = 4;
  localparam int EN_BIT = 0;
  localparam int SEL_BIT = 1;
  localparam int ACK_BIT = 2;
  localparam int PEND_BIT = 2;
  localparam int FLAG_BIT = 3;

  typedef struct packed {
    logic reloadEdge;
    logic reloadSel;
  } vdetStrobeT;
endpackage

// File: rtl/vdet_sync.sv
module vdet_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/vdet_datapath.sv
module vdet_datapath
  import vdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyCmp,
  input  logic       extCmp,
  input  logic       lvrOptEn,
  input  logic       srcSel,
  input  vdetStrobeT strobe,
  output logic       flag,
  output logic       toggle
);
  logic supS, extS;
  logic prevFlag, activeQ, reloadVal;

  vdet_sync #(.STAGES(SYNC_STAGES)) u_syncSup (
    .clk(clk), .rstN(rstN), .din(supplyCmp), .dout(supS));
  vdet_sync #(.STAGES(SYNC_STAGES)) u_syncExt (
    .clk(clk), .rstN(rstN), .din(extCmp), .dout(extS));

  assign flag      = lvrOptEn & (srcSel ? extS : supS);
  assign reloadVal = lvrOptEn & (strobe.reloadSel ? extS : supS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFlag <= 1'b0;
      activeQ  <= 1'b0;
    end else begin
      activeQ  <= lvrOptEn;
      prevFlag <= strobe.reloadEdge ? reloadVal : flag;
    end
  end

  assign toggle = lvrOptEn & activeQ & (flag ^ prevFlag);

  // R9
  reload_no_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.reloadEdge) && $stable(supS) && $stable(extS) && $stable(lvrOptEn)
      |-> !toggle);
endmodule

// File: rtl/vdet_ctrl.sv
module vdet_ctrl
  import vdet_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWr,
  input  logic [WR_W-1:0] regWdata,
  input  logic            regRd,
  input  logic            flag,
  input  logic            toggle,
  input  logic            rstDelayBusy,
  output logic            srcSel,
  output vdetStrobeT      strobe,
  output logic            pending,
  output logic [RD_W-1:0] regRdata
);
  logic intEn;
  logic setPend, clrPend;

  assign strobe.reloadEdge = regWr && (regWdata[SEL_BIT] != srcSel);
  assign strobe.reloadSel  = regWdata[SEL_BIT];

  assign setPend = !rstDelayBusy &&
                   ((intEn && toggle) ||
                    (regWr && regWdata[EN_BIT] && !intEn && flag));
  assign clrPend = regWr && regWdata[ACK_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn    <= 1'b0;
      srcSel   <= 1'b0;
      pending  <= 1'b0;
      regRdata <= '0;
    end else begin
      if (regWr) begin
        intEn  <= regWdata[EN_BIT];
        srcSel <= regWdata[SEL_BIT];
      end
      if (setPend)      pending <= 1'b1;
      else if (clrPend) pending <= 1'b0;
      if (regRd) begin
        regRdata[EN_BIT]   <= intEn;
        regRdata[SEL_BIT]  <= srcSel;
        regRdata[PEND_BIT] <= pending;
        regRdata[FLAG_BIT] <= flag;
      end
    end
  end

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending && !(regWr && regWdata[ACK_BIT]) |=> pending);
  // R6
  delay_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstDelayBusy && !pending |=> !pending);
  // R11
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(intEn) || $past(regWr && regWdata[EN_BIT]));
  // R10
  rd_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |=> $stable(regRdata));
endmodule

// File: rtl/vdet_irq.sv
module vdet_irq
  import vdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            supplyCmp,
  input  logic            extCmp,
  input  logic            lvrOptEn,
  input  logic            rstDelayBusy,
  input  logic            regWr,
  input  logic [WR_W-1:0] regWdata,
  input  logic            regRd,
  output logic [RD_W-1:0] regRdata,
  output logic            irqReq
);
  logic       flag, toggle, srcSel, pending;
  vdetStrobeT strobe;

  vdet_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .supplyCmp(supplyCmp), .extCmp(extCmp),
    .lvrOptEn(lvrOptEn), .srcSel(srcSel), .strobe(strobe),
    .flag(flag), .toggle(toggle));

  vdet_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regWdata(regWdata),
    .regRd(regRd), .flag(flag), .toggle(toggle),
    .rstDelayBusy(rstDelayBusy), .srcSel(srcSel), .strobe(strobe),
    .pending(pending), .regRdata(regRdata));

  assign irqReq = pending;

  // R4
  opt_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lvrOptEn && !irqReq |=> !irqReq);
endmodule

// File: tb/vdet_irq_tb.sv
module vdet_irq_tb;
  localparam int SYNC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyCmp = 1'b0, extCmp = 1'b0, lvrOptEn = 1'b0, rstDelayBusy = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [2:0] regWdata = '0;
  logic [3:0] regRdata;
  logic irqReq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R7";

  // behavioural reference state
  bit mSup[SYNC];
  bit mExt[SYNC];
  bit mEn, mSel, mPend, mPrev, mAct;
  bit [3:0] mRd;

  always #10 clk = ~clk;

  vdet_irq #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rstN(rstN), .supplyCmp(supplyCmp), .extCmp(extCmp),
    .lvrOptEn(lvrOptEn), .rstDelayBusy(rstDelayBusy), .regWr(regWr),
    .regWdata(regWdata), .regRd(regRd), .regRdata(regRdata), .irqReq(irqReq));

  always @(posedge clk) begin
    bit s, e, f, tg, setP;
    if (!rstN) begin
      for (int i = 0; i < SYNC; i++) begin mSup[i] = 0; mExt[i] = 0; end
      mEn = 0; mSel = 0; mPend = 0; mPrev = 0; mAct = 0; mRd = '0;
    end else begin
      s = mSup[SYNC-1];
      e = mExt[SYNC-1];
      f = lvrOptEn & (mSel ? e : s);
      tg = lvrOptEn & mAct & (f != mPrev);
      setP = !rstDelayBusy & ((mEn & tg) | (regWr & regWdata[0] & !mEn & f));
      if (regRd) mRd = {f, mPend, mSel, mEn};
      if (setP) mPend = 1;
      else if (regWr && regWdata[2]) mPend = 0;
      if (regWr && (regWdata[1] != mSel)) mPrev = lvrOptEn & (regWdata[1] ? e : s);
      else mPrev = f;
      mAct = lvrOptEn;
      if (regWr) begin mEn = regWdata[0]; mSel = regWdata[1]; end
      for (int i = SYNC - 1; i > 0; i--) begin mSup[i] = mSup[i-1]; mExt[i] = mExt[i-1]; end
      mSup[0] = supplyCmp;
      mExt[0] = extCmp;
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    checks++;
    if (irqReq !== mPend || regRdata !== mRd) begin
      fails++;
      $display("FAIL %s cycle %0d: irqReq=%b rdata=%h expected irqReq=%b rdata=%h",
               curReq, cycles, irqReq, regRdata, mPend, mRd);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: cycle=%0d expected completion", cycles);
      finishRun();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit [2:0] d);
    regWr = 1'b1; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic rd(output bit [3:0] v);
    regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    v = regRdata;
  endtask

  task automatic expectEq(string req, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  initial begin
    bit [3:0] v;
    tick(3);
    // R7 reset state
    expectEq("R7", irqReq, 0);
    expectEq("R7", regRdata, 0);
    @(negedge clk); rstN = 1'b1;
    rd(v); expectEq("R7", v, 4'h0);

    // R4: option off
    curReq = "R4";
    wr(3'b001);
    supplyCmp = 1; tick(SYNC + 2);
    rd(v); expectEq("R4", v[3], 0);
    supplyCmp = 0; tick(SYNC + 2);
    expectEq("R4", irqReq, 0);
    wr(3'b000);

    // R1 / R2: source select and live flag
    curReq = "R2";
    lvrOptEn = 1; supplyCmp = 1; extCmp = 0; tick(SYNC + 2);
    rd(v); expectEq("R2", v, 4'b1000);
    curReq = "R1";
    wr(3'b010); tick(1);
    rd(v); expectEq("R1", v, 4'b0010);
    extCmp = 1; tick(SYNC + 1);
    rd(v); expectEq("R1", v, 4'b1010);
    wr(3'b000); extCmp = 0; tick(1);

    // R11: disabled transitions
    curReq = "R11";
    supplyCmp = 0; tick(SYNC + 2);
    supplyCmp = 1; tick(SYNC + 2);
    expectEq("R11", irqReq, 0);
    supplyCmp = 0; tick(SYNC + 2);

    // R3: both directions
    curReq = "R3";
    wr(3'b001);
    supplyCmp = 1; tick(SYNC + 2);
    expectEq("R3", irqReq, 1);
    wr(3'b101); tick(1);
    expectEq("R8", irqReq, 0);
    supplyCmp = 0; tick(SYNC + 2);
    expectEq("R3", irqReq, 1);

    // R8: sticky without acknowledge
    curReq = "R8";
    wr(3'b001); tick(6);
    expectEq("R8", irqReq, 1);
    wr(3'b101);
    expectEq("R8", irqReq, 0);

    // R5: enable with flag already high
    curReq = "R5";
    wr(3'b000);
    supplyCmp = 1; tick(SYNC + 2);
    expectEq("R5", irqReq, 0);
    wr(3'b001);
    expectEq("R5", irqReq, 1);
    wr(3'b101);
    supplyCmp = 0; tick(SYNC + 2);
    expectEq("R5", irqReq, 1);
    wr(3'b101); tick(1);

    // R9: select change with disagreeing comparators
    curReq = "R9";
    extCmp = 1; tick(SYNC + 2);
    wr(3'b011); tick(4);
    expectEq("R9", irqReq, 0);
    wr(3'b001); tick(4);
    expectEq("R9", irqReq, 0);

    // R6: transitions during the reset delay
    curReq = "R6";
    rstDelayBusy = 1;
    supplyCmp = 1; tick(SYNC + 2);
    rstDelayBusy = 0; tick(3);
    expectEq("R6", irqReq, 0);
    rstDelayBusy = 1; wr(3'b000); wr(3'b001); tick(2);
    expectEq("R6", irqReq, 0);
    rstDelayBusy = 0;

    // R10 plus everything: random traffic
    curReq = "R10";
    for (int i = 0; i < 3000; i++) begin
      supplyCmp = ($urandom_range(0, 7) == 0) ? ~supplyCmp : supplyCmp;
      extCmp = ($urandom_range(0, 5) == 0) ? ~extCmp : extCmp;
      lvrOptEn = ($urandom_range(0, 150) == 0) ? ~lvrOptEn : lvrOptEn;
      rstDelayBusy = ($urandom_range(0, 40) == 0);
      regWr = ($urandom_range(0, 4) == 0);
      regWdata = 3'($urandom_range(0, 7));
      regRd = ($urandom_range(0, 2) == 0);
      @(negedge clk);
    end
    regWr = 0; regRd = 0; tick(2);
    finishRun();
  end
endmodule